// File: doc/BRIEF.md
# Serial Register Command Port

This block lets an external controller reach a bank of four 8-bit modem registers over a few pins: a 3-bit register address, an active-low read strobe, an active-low write strobe, a shift clock and one data line. The data line is split at the pad into an input, an output and an output enable, so that a pad cell outside the block can form the bidirectional pin.

To read, the controller sets the address and pulls the read strobe low. Bit 0 of the addressed register then appears on the data line. Each rising shift-clock edge after that presents the next bit, so the byte comes out least significant bit first. To write, the controller leaves the read strobe high and clocks eight data bits in, LSB first, on rising shift-clock edges. It then pulses the write strobe low, and the collected byte is committed to the addressed register when the strobe rises.

All pins are oversampled in the block's system clock through a synchronizer, so the port is fully synchronous to `clk`. Addresses 0, 1 and 3 are read/write registers that drive the modem's controls. Address 2 is a read-only status register that reloads from a status bus on every clock. Addresses 4 to 7 are unmapped.

Top module: `sercmd_port`

## Requirements
- R1: A synchronous active-low reset clears registers 0, 1 and 3 to zero and holds the output enable low.
- R2: The output enable rises once the synchronized read strobe is seen low, and it falls once the synchronized read strobe is seen high again. It is never high while the read strobe is high.
- R3: Once a read begins, the data output shows bit 0 of the addressed register's value as captured at the falling edge of the read strobe.
- R4: During a read, each rising shift-clock edge advances the data output by one bit, so that bits 1 to 7 follow in order.
- R5: With the read strobe high, each rising shift-clock edge shifts the data input into an 8-bit collector. Bit 0 is the first bit sent and bit 7 the last. On the rising edge of the write strobe, the byte is written into register 0, 1 or 3 if the address is 0, 1 or 3 respectively.
- R6: Registers 0, 1 and 3 change only on a write-strobe rising edge. Shifting bits in, or holding the write strobe low, leaves them unchanged.
- R7: A write to address 2 has no effect. Reading address 2 returns the current status bus value.
- R8: Reading any address from 4 to 7 returns 0x00. Writes to those addresses change no register.
- R9: The status register equals the status bus value from the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample all pins |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Register address |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe, commits on its rising edge |
| sclk | input | 1 | Shift clock, acting on its rising edge |
| dq_in | input | 1 | Data from the pad (write data) |
| dq_out | output | 1 | Data to the pad (read data) |
| dq_oe | output | 1 | Pad output enable, high only while a read is in progress |
| status_in | input | 8 | Monitored status bits, loaded into register 2 |
| ctrl_a_q | output | 8 | Contents of register 0 |
| ctrl_b_q | output | 8 | Contents of register 1 |
| tone_q | output | 8 | Contents of register 3 |

## Verification
Random sequences of writes and reads cover all eight addresses, with random data and random status values. Byte values are not symmetric, so any bit-order reversal, off-by-one shift or wrong register decode shows up in the value read back. Directed cases cover the following:
- a write to the status address followed by a read, which separates "ignored" from "stored";
- writes to unmapped addresses followed by reads of every real register;
- a check of the register outputs while the write strobe is held low, which separates a commit on the rising edge from a commit on the falling edge or during shifting.

// File: rtl/sercmd_pkg.sv
// Package: shared widths and the register address map for the serial command port.
// Assumes a four-entry bank inside an eight-location address space.
package sercmd_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL_A = 3'd0,
        A_CTRL_B = 3'd1,
        A_STATUS = 3'd2,
        A_TONE   = 3'd3
    } reg_addr_e;
endpackage

// File: rtl/sercmd_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous pins.
// Assumes each bit is an independent level. RST_VAL sets the idle level after reset.
module sercmd_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Purpose: capture the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[s] <= RST_VAL;
                else        stage[s] <= d;
            end
        end else begin : g_next
            // Purpose: pass the value along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[s] <= RST_VAL;
                else        stage[s] <= stage[s-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/sercmd_shifter.sv
// Module: read serializer and write collector.
// Assumes one-cycle event pulses from the top (read fall, shift-clock rise).
// No write shifting takes place while a read is active.
module sercmd_shifter #(
    parameter int W = sercmd_pkg::REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_fall,
    input  logic         rd_lvl,
    input  logic         sclk_rise,
    input  logic         din,
    input  logic [W-1:0] load_val,
    output logic         dout,
    output logic         oe,
    output logic [W-1:0] wdata
);
    logic [W-1:0] rd_sh;
    logic         oe_q;

    // Purpose: open a read on the strobe fall and close it when the strobe returns high.
    always_ff @(posedge clk) begin
        if (!rst_n)       oe_q <= 1'b0;
        else if (rd_fall) oe_q <= 1'b1;
        else if (rd_lvl)  oe_q <= 1'b0;
    end

    // Purpose: snapshot the addressed byte, then shift it out LSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)                 rd_sh <= '0;
        else if (rd_fall)           rd_sh <= load_val;
        else if (oe_q && sclk_rise) rd_sh <= {1'b0, rd_sh[W-1:1]};
    end

    // Purpose: collect write bits LSB first while no read is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)                            wdata <= '0;
        else if (!oe_q && rd_lvl && sclk_rise) wdata <= {din, wdata[W-1:1]};
    end

    assign dout = rd_sh[0];
    assign oe   = oe_q;
endmodule

// File: rtl/sercmd_regbank.sv
// Module: four-entry register bank with a read-only status slot.
// Assumes the commit pulse lasts one clock. Unmapped addresses read zero.
module sercmd_regbank
    import sercmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              commit,
    input  logic [REG_W-1:0]  wdata,
    input  logic [REG_W-1:0]  status_in,
    output logic [REG_W-1:0]  rd_value,
    output logic [REG_W-1:0]  ctrl_a,
    output logic [REG_W-1:0]  ctrl_b,
    output logic [REG_W-1:0]  tone,
    output logic [REG_W-1:0]  status
);
    // Purpose: commit write data into the writable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_a <= '0;
            ctrl_b <= '0;
            tone   <= '0;
        end else if (commit) begin
            case (addr)
                A_CTRL_A: ctrl_a <= wdata;
                A_CTRL_B: ctrl_b <= wdata;
                A_TONE:   tone   <= wdata;
                default:  ;
            endcase
        end
    end

    // Purpose: reload the status register from the monitor bus every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= status_in;
    end

    // Purpose: select the byte for a read.
    always_comb begin
        case (addr)
            A_CTRL_A: rd_value = ctrl_a;
            A_CTRL_B: rd_value = ctrl_b;
            A_STATUS: rd_value = status;
            A_TONE:   rd_value = tone;
            default:  rd_value = '0;
        endcase
    end
endmodule

// File: rtl/sercmd_port.sv
// Module: top of the serial command port.
// Oversamples the pins, turns strobe and clock edges into one-cycle pulses,
// and connects the shifter to the register bank.
// Assumes every pin level is held for longer than SYNC_STAGES + 1 clocks.
module sercmd_port
    import sercmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              sclk,
    input  logic              dq_in,
    output logic              dq_out,
    output logic              dq_oe,
    input  logic [REG_W-1:0]  status_in,
    output logic [REG_W-1:0]  ctrl_a_q,
    output logic [REG_W-1:0]  ctrl_b_q,
    output logic [REG_W-1:0]  tone_q
);
    localparam int PIN_W = ADDR_W + 4;
    localparam logic [PIN_W-1:0] PIN_IDLE = {{ADDR_W{1'b0}}, 1'b1, 1'b1, 1'b0, 1'b0};

    logic [ADDR_W-1:0] addr_s;
    logic              rd_lvl, wr_lvl, sclk_lvl, din_lvl;
    logic              rd_d, wr_d, sclk_d;
    logic              rd_fall, wr_rise, sclk_rise;
    logic [REG_W-1:0]  rd_value, wdata, status_q;

    sercmd_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({addr, rd_n, wr_n, sclk, dq_in}),
        .q     ({addr_s, rd_lvl, wr_lvl, sclk_lvl, din_lvl})
    );

    // Purpose: keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_d   <= 1'b1;
            wr_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            rd_d   <= rd_lvl;
            wr_d   <= wr_lvl;
            sclk_d <= sclk_lvl;
        end
    end

    assign rd_fall   = rd_d & ~rd_lvl;
    assign wr_rise   = ~wr_d & wr_lvl;
    assign sclk_rise = ~sclk_d & sclk_lvl;

    sercmd_shifter #(.W(REG_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_fall   (rd_fall),
        .rd_lvl    (rd_lvl),
        .sclk_rise (sclk_rise),
        .din       (din_lvl),
        .load_val  (rd_value),
        .dout      (dq_out),
        .oe        (dq_oe),
        .wdata     (wdata)
    );

    sercmd_regbank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr_s),
        .commit    (wr_rise),
        .wdata     (wdata),
        .status_in (status_in),
        .rd_value  (rd_value),
        .ctrl_a    (ctrl_a_q),
        .ctrl_b    (ctrl_b_q),
        .tone      (tone_q),
        .status    (status_q)
    );
endmodule

// File: rtl/sercmd_port_chk.sv
// Module: property checker for sercmd_port, attached with bind below.
// Only observes. Reads the pins and the internal event pulses.
module sercmd_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_lvl,
    input logic       rd_fall,
    input logic       wr_rise,
    input logic [2:0] addr_s,
    input logic [7:0] rd_value,
    input logic [7:0] wdata,
    input logic [7:0] status_q,
    input logic [7:0] status_in,
    input logic       dq_out,
    input logic       dq_oe,
    input logic [7:0] ctrl_a_q,
    input logic [7:0] ctrl_b_q,
    input logic [7:0] tone_q
);
    AST_OE_OFF_AFTER_RD_HIGH: assert property (@(posedge clk) disable iff (!rst_n) rd_lvl |=> !dq_oe); // R2
    AST_OE_ON_AFTER_RD_FALL: assert property (@(posedge clk) disable iff (!rst_n) rd_fall |=> dq_oe); // R2
    AST_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n) rd_fall |=> dq_out == $past(rd_value[0])); // R3
    AST_COMMIT_CTRL_A: assert property (@(posedge clk) disable iff (!rst_n) (wr_rise && addr_s == 3'd0) |=> ctrl_a_q == $past(wdata)); // R5
    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !wr_rise |=> ($stable(ctrl_a_q) && $stable(ctrl_b_q) && $stable(tone_q))); // R6
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) addr_s[2] |-> rd_value == 8'h00); // R8
    AST_STATUS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> status_q == $past(status_in)); // R9
endmodule

bind sercmd_port sercmd_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_lvl    (rd_lvl),
    .rd_fall   (rd_fall),
    .wr_rise   (wr_rise),
    .addr_s    (addr_s),
    .rd_value  (rd_value),
    .wdata     (wdata),
    .status_q  (status_q),
    .status_in (status_in),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .ctrl_a_q  (ctrl_a_q),
    .ctrl_b_q  (ctrl_b_q),
    .tone_q    (tone_q)
);

// File: tb/sim_sercmd_port.sv
// Bench: random and directed register traffic through the serial pins.
// Every read result is compared with a bench-side register model.
module sim_sercmd_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       rd_n = 1'b1, wr_n = 1'b1, sclk = 1'b0, dq_in = 1'b0;
    logic       dq_out, dq_oe;
    logic [7:0] status_in = '0;
    logic [7:0] ctrl_a_q, ctrl_b_q, tone_q;

    int         n_chk = 0, n_bad = 0;
    logic [7:0] mdl [4];
    bit         done = 1'b0;

    always #5 clk = ~clk;

    sercmd_port u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n), .sclk(sclk),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .status_in(status_in),
        .ctrl_a_q(ctrl_a_q), .ctrl_b_q(ctrl_b_q), .tone_q(tone_q)
    );

    // Expected read value: the model for writable slots, the live bus for status, zero when unmapped.
    function automatic logic [7:0] exp_read(input logic [2:0] a);
        if (a[2])       return 8'h00;
        if (a == 3'd2)  return status_in;
        return mdl[a[1:0]];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse_sclk();
        sclk = 1'b1; settle();
        sclk = 1'b0; settle();
    endtask

    task automatic do_read(input logic [2:0] a, output logic [7:0] got);
        addr = a; settle();
        chk(dq_oe == 1'b0, "R2 idle oe", dq_oe, 0);
        rd_n = 1'b0; settle();
        chk(dq_oe == 1'b1, "R2 oe during read", dq_oe, 1);
        got[0] = dq_out;
        for (int i = 1; i < 8; i++) begin
            pulse_sclk();
            got[i] = dq_out;
        end
        rd_n = 1'b1; settle();
        chk(dq_oe == 1'b0, "R2 oe after read", dq_oe, 0);
    endtask

    task automatic check_read(input logic [2:0] a, input string req);
        logic [7:0] got, exp;
        exp = exp_read(a);
        do_read(a, got);
        chk(got == exp, req, got, exp);
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        logic [7:0] ca, cb, tn;
        addr = a;
        for (int i = 0; i < 8; i++) begin
            dq_in = d[i];
            settle();
            pulse_sclk();
        end
        ca = ctrl_a_q; cb = ctrl_b_q; tn = tone_q;
        wr_n = 1'b0; settle();
        chk(ctrl_a_q == ca && ctrl_b_q == cb && tone_q == tn, "R6 no commit before strobe rise",
            {ctrl_a_q, ctrl_b_q, tone_q}, {ca, cb, tn});
        wr_n = 1'b1; settle();
        if (!a[2] && a != 3'd2) mdl[a[1:0]] = d;
        chk(ctrl_a_q == mdl[0] && ctrl_b_q == mdl[1] && tone_q == mdl[3], "R5 register outputs after write",
            {ctrl_a_q, ctrl_b_q, tone_q}, {mdl[0], mdl[1], mdl[3]});
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5EC0_11D5);
        for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
        repeat (4) @(negedge clk);
        chk(ctrl_a_q == 0 && ctrl_b_q == 0 && tone_q == 0, "R1 reset regs", {ctrl_a_q, ctrl_b_q, tone_q}, 0);
        chk(dq_oe == 1'b0, "R1 reset oe", dq_oe, 0);
        rst_n = 1'b1; settle();

        // Directed corner cases.
        do_write(3'd0, 8'hA5); check_read(3'd0, "R3 R4 read ctrl_a");
        do_write(3'd1, 8'h01); check_read(3'd1, "R4 read ctrl_b lsb only");
        do_write(3'd3, 8'h80); check_read(3'd3, "R4 read tone msb only");
        status_in = 8'h3C; settle();
        do_write(3'd2, 8'hC3); check_read(3'd2, "R7 status write ignored");
        status_in = 8'h96; settle();
        check_read(3'd2, "R9 status follows bus");
        do_write(3'd5, 8'hFF); do_write(3'd7, 8'h5A);
        check_read(3'd5, "R8 unmapped reads zero");
        for (int i = 0; i < 4; i++) check_read(3'(i), "R8 unmapped write no effect");

        // Constrained random traffic.
        for (int n = 0; n < 60; n++) begin
            int unsigned op;
            op = $urandom % 3;
            if (op == 0)      do_write(3'($urandom % 8), 8'($urandom));
            else if (op == 1) check_read(3'($urandom % 8), "R3 R4 R5 random read");
            else begin status_in = 8'($urandom); settle(); end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule